// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer that software arms and services only by writing magic values to a 16-bit key register. A 12-bit down-counter advances on a prescaled low-speed tick enable, which stands in for an oscillator that keeps running when the main clock fails. If the counter runs out while the watchdog is active, the block raises a one-cycle reset request. It then reloads and keeps counting, so an unserviced system sees a repeating request.

The prescaler and reload registers are write-protected. Software must first write an unlock key. Any other key value locks them again, and that includes the refresh key. A strap input can make the watchdog run from the end of reset with no key write at all. Once the watchdog is running, software cannot stop it.

Register addresses on the write port: 0 is the key register, 1 is the prescaler, 2 is the reload value. Address 3 is unused.

Top module: `key_wdg`

## Requirements
- R1: With the strap low, the watchdog is idle after reset and never requests a reset, whatever the ticks do, until key 0xCCCC is written at address 0. It then counts down from 0xFFF.
- R2: A prescaled step can arrive while the watchdog is running and the counter holds 0. If so, `rst_req_o` is high for exactly the following cycle and the counter reloads from the reload register. With ticks on every cycle, rising edges of the request are D×(R+1) cycles apart, where D is the divide and R the reload value.
- R3: Writing key 0xAAAA loads the reload value into the counter and restarts the prescaler phase. Refreshing more often than the timeout prevents every reset request.
- R4: Writes to the prescaler (address 1, data bits [2:0]) and to the reload register (address 2, data bits [11:0]) are ignored unless the registers are unlocked.
- R5: Writing key 0x5555 unlocks the registers. Any other value written to the key register locks them again, including 0xAAAA.
- R6: Prescaler code n selects a divide of 4×2^n ticks. Codes 6 and 7 both divide by 256.
- R7: The counter and prescaler advance only in cycles where `tick_i` is high. With no ticks, no reset request is produced.
- R8: Once the watchdog is running, no key write stops it. Only a system reset returns it to idle.
- R9: `hw_start_i` is sampled during reset. When it is high, the watchdog runs from reset release, counting from 0xFFF with divide 4, so its first request comes 16384 ticks later.
- R10: A refresh key written in the same cycle as an expiry wins: no reset request is produced and the counter loads the reload value.
- R11: After reset the reload register is 0xFFF, the prescaler code is 0, the registers are locked and `rst_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous active-high system reset |
| tick_i | input | 1 | Low-speed tick enable |
| hw_start_i | input | 1 | Strap: run from reset without a key write |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 key, 1 prescaler, 2 reload) |
| wr_data_i | input | 16 | Write data |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
On every cycle the assertions hold several properties: the request is one cycle wide and only follows a running state, a running watchdog never returns to idle, a locked write leaves the reload value unchanged, any non-unlock key locks the registers, and a refresh suppresses the next request. Other behaviour shows only in the bench's scenarios, where a behavioural model is compared against the output on every clock. These cover exact request periods for each divide code, the codes 6 and 7 sharing one divide, refresh that is frequent enough to starve the counter, a tick stall, the refresh that collides with expiry, and the strap-driven first timeout.

// File: rtl/key_wdg_pkg.sv
package key_wdg_pkg;

    localparam int KEY_W     = 16;
    localparam int CNT_W     = 12;
    localparam int PRE_W     = 3;
    localparam int ADDR_W    = 2;
    localparam int BASE_LOG2 = 2;
    localparam int MAX_EXP   = 6;

    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;

    typedef enum logic [1:0] {
        SEL_KEY  = 2'd0,
        SEL_PRE  = 2'd1,
        SEL_RLD  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic start;
        logic refresh;
        logic unlock;
        logic relock;
    } key_cmd_t;

    function automatic key_cmd_t decode_key(input logic [KEY_W-1:0] value, input logic hit);
        key_cmd_t c;
        c.start   = hit && (value == KEY_START);
        c.refresh = hit && (value == KEY_REFRESH);
        c.unlock  = hit && (value == KEY_UNLOCK);
        c.relock  = hit && (value != KEY_UNLOCK);
        return c;
    endfunction

endpackage

// File: rtl/wdg_key_ctrl.sv
module wdg_key_ctrl
    import key_wdg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PRE_W,
    parameter int CW = CNT_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [KEY_W-1:0]  wr_data_i,
    output key_cmd_t          cmd_o,
    output logic              unlocked_o,
    output logic [PW-1:0]     pre_o,
    output logic [CW-1:0]     rld_o
);

    logic key_hit, pre_hit, rld_hit;

    always_comb begin
        key_hit = wr_en_i && (wr_addr_i == AW'(SEL_KEY));
        pre_hit = wr_en_i && (wr_addr_i == AW'(SEL_PRE));
        rld_hit = wr_en_i && (wr_addr_i == AW'(SEL_RLD));
        cmd_o   = decode_key(wr_data_i, key_hit);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            unlocked_o <= 1'b0;
            pre_o      <= '0;
            rld_o      <= '1;
        end else begin
            if (cmd_o.unlock) begin
                unlocked_o <= 1'b1;
            end else if (cmd_o.relock) begin
                unlocked_o <= 1'b0;
            end
            if (pre_hit && unlocked_o) begin
                pre_o <= wr_data_i[PW-1:0];
            end
            if (rld_hit && unlocked_o) begin
                rld_o <= wr_data_i[CW-1:0];
            end
        end
    end

endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int PW        = 3,
    parameter int BASE_LOG2 = 2,
    parameter int MAX_EXP   = 6
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic          clear_i,
    input  logic [PW-1:0] pre_i,
    output logic          step_o
);

    localparam int PS_W = BASE_LOG2 + MAX_EXP;
    localparam logic [PS_W-1:0] PS_FULL = '1;

    logic [PS_W-1:0] ps_q;
    logic [PW-1:0]   exp_sel;
    logic [PW-1:0]   exp_gap;
    logic [PS_W-1:0] term;

    always_comb begin
        exp_sel = (pre_i > PW'(MAX_EXP)) ? PW'(MAX_EXP) : pre_i;
        exp_gap = PW'(MAX_EXP) - exp_sel;
        term    = PS_FULL >> exp_gap;
        step_o  = run_i && tick_i && (ps_q >= term);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ps_q <= '0;
        end else if (clear_i) begin
            ps_q <= '0;
        end else if (run_i && tick_i) begin
            ps_q <= step_o ? '0 : ps_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdg_downcounter.sv
module wdg_downcounter #(
    parameter int CW = 12
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          hw_start_i,
    input  logic          start_i,
    input  logic          refresh_i,
    input  logic          step_i,
    input  logic [CW-1:0] rld_i,
    output logic          running_o,
    output logic          rst_req_o
);

    logic [CW-1:0] cnt_q;
    logic          expire;

    always_comb begin
        expire = running_o && step_i && (cnt_q == '0);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            running_o <= hw_start_i;
            cnt_q     <= '1;
            rst_req_o <= 1'b0;
        end else begin
            rst_req_o <= expire && !refresh_i;
            if (start_i) begin
                running_o <= 1'b1;
            end
            if (refresh_i) begin
                cnt_q <= rld_i;
            end else if (start_i && !running_o) begin
                cnt_q <= '1;
            end else if (expire) begin
                cnt_q <= rld_i;
            end else if (step_i) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/key_wdg.sv
module key_wdg
    import key_wdg_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = KEY_W,
    parameter int PW  = PRE_W,
    parameter int CW  = CNT_W,
    parameter int BL2 = BASE_LOG2,
    parameter int MXE = MAX_EXP
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          tick_i,
    input  logic          hw_start_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          rst_req_o
);

    key_cmd_t      cmd;
    logic          unlocked;
    logic [PW-1:0] pre_q;
    logic [CW-1:0] rld_q;
    logic          running;
    logic          step;
    logic          ps_clear;

    wdg_key_ctrl #(.AW(AW), .PW(PW), .CW(CW)) u_keys (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .cmd_o      (cmd),
        .unlocked_o (unlocked),
        .pre_o      (pre_q),
        .rld_o      (rld_q)
    );

    always_comb begin
        ps_clear = cmd.refresh || (cmd.start && !running);
    end

    wdg_prescaler #(.PW(PW), .BASE_LOG2(BL2), .MAX_EXP(MXE)) u_pre (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .run_i   (running),
        .tick_i  (tick_i),
        .clear_i (ps_clear),
        .pre_i   (pre_q),
        .step_o  (step)
    );

    wdg_downcounter #(.CW(CW)) u_cnt (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .hw_start_i (hw_start_i),
        .start_i    (cmd.start),
        .refresh_i  (cmd.refresh),
        .step_i     (step),
        .rld_i      (rld_q),
        .running_o  (running),
        .rst_req_o  (rst_req_o)
    );

endmodule

// File: rtl/key_wdg_chk.sv
module key_wdg_chk #(
    parameter int AW = 2,
    parameter int DW = 16,
    parameter int CW = 12
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          wr_en_i,
    input logic [AW-1:0] wr_addr_i,
    input logic [DW-1:0] wr_data_i,
    input logic          running,
    input logic          unlocked,
    input logic [CW-1:0] rld_q,
    input logic          rst_req_o
);

    // R2
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_req_o |=> !rst_req_o);

    // R1
    req_needs_run_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_req_o |-> $past(running));

    // R8
    no_stop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        running |=> running);

    // R4
    locked_rld_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_addr_i == AW'(2) && !unlocked) |=> $stable(rld_q));

    // R5
    relock_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_addr_i == AW'(0) && wr_data_i != DW'(16'h5555)) |=> !unlocked);

    // R10
    refresh_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_addr_i == AW'(0) && wr_data_i == DW'(16'hAAAA)) |=> !rst_req_o);

endmodule

bind key_wdg key_wdg_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .running   (running),
    .unlocked  (unlocked),
    .rld_q     (rld_q),
    .rst_req_o (rst_req_o)
);

// File: tb/tb_key_wdg.sv
module tb_key_wdg;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        hw = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] data = 16'h0;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pulses = 0;
    int prev_rise = 0;
    int last_rise = 0;
    bit done = 0;

    // behavioural reference state
    int m_run, m_cnt, m_ps, m_unl, m_rld, m_pre, m_rst;

    always #(CLK_PERIOD/2) clk = ~clk;

    key_wdg dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .tick_i     (tick),
        .hw_start_i (hw),
        .wr_en_i    (we),
        .wr_addr_i  (addr),
        .wr_data_i  (data),
        .rst_req_o  (rst_req)
    );

    function automatic int mterm(int p);
        return (4 << ((p > 6) ? 6 : p)) - 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_run = hw; m_cnt = 4095; m_ps = 0; m_unl = 0;
            m_rld = 4095; m_pre = 0; m_rst = 0;
        end else begin
            bit kw, rf, st, stp, exp_now;
            int old_unl;
            kw = we && addr == 2'd0;
            rf = kw && data == 16'hAAAA;
            st = kw && data == 16'hCCCC;
            stp = m_run != 0 && tick && m_ps >= mterm(m_pre);
            exp_now = stp && m_cnt == 0;
            m_rst = exp_now && !rf;
            if (rf || (st && m_run == 0)) m_ps = 0;
            else if (m_run != 0 && tick) m_ps = stp ? 0 : m_ps + 1;
            if (rf) m_cnt = m_rld;
            else if (st && m_run == 0) m_cnt = 4095;
            else if (exp_now) m_cnt = m_rld;
            else if (stp) m_cnt = m_cnt - 1;
            if (st) m_run = 1;
            old_unl = m_unl;
            if (kw) m_unl = (data == 16'h5555);
            if (we && old_unl != 0 && addr == 2'd1) m_pre = data[2:0];
            if (we && old_unl != 0 && addr == 2'd2) m_rld = data[11:0];
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst && !done) begin
            chk(rst_req === m_rst[0], "R2 per-cycle model compare", rst_req, m_rst);
            if (rst_req) begin
                prev_rise = last_rise;
                last_rise = cyc;
                pulses++;
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        we = 1'b1; addr = a; data = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_pulses(input int k);
        int target = pulses + k;
        int n = 0;
        while (pulses < target && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int p0, t0;
        bit found;
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(rst_req == 1'b0, "R11 reset request low", rst_req, 0);

        // R1: idle without start key
        cycles(300);
        chk(pulses == 0, "R1 idle never requests", pulses, 0);

        // R4 / R11: locked writes ignored, reload stays 0xFFF
        wr(2'd2, 16'h0003);
        wr(2'd1, 16'h0005);
        wr(2'd0, 16'hCCCC);
        wr(2'd0, 16'hAAAA);
        cycles(200);
        chk(pulses == 0, "R4 locked reload write ignored", pulses, 0);

        // R2 / R6: divide 4, reload 3 -> period 16
        wr(2'd0, 16'h5555); wr(2'd2, 16'h0003);
        wr(2'd0, 16'h5555); wr(2'd1, 16'h0000);
        wr(2'd0, 16'hAAAA);
        wait_pulses(2);
        chk(last_rise - prev_rise == 16, "R2 period divide 4 reload 3", last_rise - prev_rise, 16);

        // R6: code 2 -> divide 16, period 64
        wr(2'd0, 16'h5555); wr(2'd1, 16'h0002);
        wr(2'd0, 16'hAAAA);
        wait_pulses(2);
        chk(last_rise - prev_rise == 64, "R6 divide 16", last_rise - prev_rise, 64);

        // R5: refresh key relocks
        wr(2'd0, 16'h5555); wr(2'd0, 16'hAAAA); wr(2'd2, 16'h0009);
        wait_pulses(2);
        chk(last_rise - prev_rise == 64, "R5 refresh key relocks", last_rise - prev_rise, 64);

        // R5: other key relocks
        wr(2'd0, 16'h5555); wr(2'd0, 16'h1234); wr(2'd1, 16'h0000);
        wait_pulses(2);
        chk(last_rise - prev_rise == 64, "R5 other key relocks", last_rise - prev_rise, 64);

        // R6: codes 7 and 6 both divide 256
        wr(2'd0, 16'h5555); wr(2'd2, 16'h0000);
        wr(2'd0, 16'h5555); wr(2'd1, 16'h0007);
        wr(2'd0, 16'hAAAA);
        wait_pulses(2);
        chk(last_rise - prev_rise == 256, "R6 code 7 divide 256", last_rise - prev_rise, 256);
        wr(2'd0, 16'h5555); wr(2'd1, 16'h0006);
        wr(2'd0, 16'hAAAA);
        wait_pulses(2);
        chk(last_rise - prev_rise == 256, "R6 code 6 divide 256", last_rise - prev_rise, 256);

        // back to divide 4, reload 3
        wr(2'd0, 16'h5555); wr(2'd1, 16'h0000);
        wr(2'd0, 16'h5555); wr(2'd2, 16'h0003);

        // R3: frequent refresh starves the counter
        wr(2'd0, 16'hAAAA);
        p0 = pulses;
        for (int i = 0; i < 25; i++) begin
            wr(2'd0, 16'hAAAA);
            cycles(6);
        end
        chk(pulses == p0, "R3 refresh prevents request", pulses - p0, 0);

        // R7: no ticks, no progress
        wr(2'd0, 16'hAAAA);
        tick = 1'b0;
        p0 = pulses;
        cycles(200);
        chk(pulses == p0, "R7 stalled without ticks", pulses - p0, 0);
        tick = 1'b1;
        t0 = cyc;
        wait_pulses(1);
        chk(last_rise - t0 >= 14 && last_rise - t0 <= 18, "R7 resumes on ticks", last_rise - t0, 16);

        // R8: other keys do not stop it
        wr(2'd0, 16'h1234); wr(2'd0, 16'hCCCC); wr(2'd0, 16'h0000);
        wait_pulses(2);
        chk(last_rise - prev_rise == 16, "R8 keeps running", last_rise - prev_rise, 16);

        // R10: refresh in the expiry cycle wins
        found = 0;
        for (int i = 0; i < 100 && !found; i++) begin
            @(negedge clk);
            if (m_run != 0 && tick && m_ps >= mterm(m_pre) && m_cnt == 0) begin
                found = 1;
                p0 = pulses;
                wr(2'd0, 16'hAAAA);
                cycles(2);
            end
        end
        chk(found, "R10 collision reached", found, 1);
        chk(pulses == p0, "R10 refresh beats expiry", pulses - p0, 0);

        // R9: hardware strap start
        rst = 1'b1; hw = 1'b1;
        cycles(3);
        rst = 1'b0;
        p0 = pulses;
        cycles(16000);
        chk(pulses == p0, "R9 no early request", pulses - p0, 0);
        wait_pulses(1);
        chk(pulses == p0 + 1, "R9 strap timeout request", pulses - p0, 1);

        cycles(5);
        finish_run();
    end

endmodule